// File: doc/BRIEF.md
# Four-Symbol Wildcard Class Classifier

This block turns a window of four consecutive input symbol classes into one equivalence-class ID, so that an automaton downstream can step over four symbols in a single cycle. A writable table holds generalized four-symbol patterns. In each of the four positions a pattern either names one concrete symbol class or carries a wildcard that accepts any symbol.

For each valid window the block looks for every valid pattern that accepts it. It returns the class ID of the pattern with the most concrete positions. When two such patterns have equal specificity, the lower table index wins. A fully concrete pattern therefore overrides the partial patterns it refines. Patterns with wildcards at the front serve windows that start fewer than four steps after the automaton's start state.

When no pattern accepts the window, the block returns a fixed default class. That class stands for the complement of everything in the table. The result is registered and comes out one clock after the window.

Top module: `ksym_classifier`

## Requirements
- R1: During and after reset, out_valid is 0, out_ecid is 0, and every table entry is invalid. Until the first write, every lookup therefore yields the default class.
- R2: The window is packed into in_syms, and symbol position p occupies bits [4p+3:4p]. Position 0 is the earliest symbol. A write places the pattern positions in wr_syms the same way. Bit p of wr_wild marks position p as a wildcard.
- R3: An entry accepts a window only when all three of these hold: its valid bit is set, each concrete position equals the window's symbol at that position, and each wildcard position may hold any symbol.
- R4: Of the entries that accept a window, the one with the most concrete positions supplies out_ecid.
- R5: When accepting entries tie on the count of concrete positions, the one with the lowest table index supplies out_ecid.
- R6: When no entry accepts a valid window, out_ecid becomes DEFAULT_ECID (31 by default).
- R7: out_valid equals in_valid delayed by one clock. The out_ecid for a window appears in that same cycle.
- R8: While in_valid is low, out_ecid keeps its previous value.
- R9: A write with wr_en high stores wr_syms, wr_wild, wr_ecid and wr_valid at wr_addr. The new entry is used by lookups presented at later clock edges. A lookup presented at the same edge as the write sees the table as it stood before the write.
- R10: Writing an entry with wr_valid low removes it from all later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A window is present on in_syms |
| in_syms | input | 16 | Four symbol class IDs, position 0 in the low nibble |
| wr_en | input | 1 | Write one table entry |
| wr_addr | input | 5 | Entry index to write |
| wr_syms | input | 16 | Pattern symbol classes, same packing as in_syms |
| wr_wild | input | 4 | Wildcard flag per position |
| wr_ecid | input | 5 | Class ID stored with the entry |
| wr_valid | input | 1 | Valid bit stored with the entry |
| out_valid | output | 1 | Result present, one clock after in_valid |
| out_ecid | output | 5 | Selected equivalence-class ID |

## Verification
A corrupted table entry, a miscounted specificity or a broken tie order shows up at the ports only when a window reaches that entry. The wrong class ID then appears on out_ecid one clock after that window. For this reason the stimulus builds overlapping patterns on purpose: a fully concrete pattern over two partial ones, and equal-score pairs at different indices. It also replays windows right after writes and removals, so that stale or lost entries are exposed within a cycle. A long stretch of random writes mixed with lookups over a four-symbol alphabet keeps many entries hitting at once. Every output is checked every clock against a behavioural model.

// File: rtl/ksym_pkg.sv
package ksym_pkg;
  localparam int K       = 4;
  localparam int SYM_W   = 4;
  localparam int ECID_W  = 5;
  localparam int DEPTH   = 32;
  localparam int AW      = $clog2(DEPTH);
  localparam int SCORE_W = $clog2(K + 1);
  localparam logic [ECID_W-1:0] DEFAULT_ECID = '1;

  typedef struct packed {
    logic                 vld;
    logic [ECID_W-1:0]    ecid;
    logic [K-1:0]         wild;
    logic [K*SYM_W-1:0]   syms;
  } kent_t;
endpackage

// File: rtl/ksym_table.sv
module ksym_table
  import ksym_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  kent_t                  wr_data,
  output kent_t [DEPTH-1:0]      tbl_o
);
  kent_t [DEPTH-1:0] tbl_q, tbl_nxt;

  always_comb begin
    tbl_nxt = tbl_q;
    if (wr_en) tbl_nxt[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else if (wr_en) tbl_q <= tbl_nxt;
  end

  assign tbl_o = tbl_q;

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ksym_match.sv
module ksym_match
  import ksym_pkg::*;
(
  input  kent_t [DEPTH-1:0]             tbl_i,
  input  logic [K*SYM_W-1:0]            win_i,
  output logic [DEPTH-1:0]              hit_o,
  output logic [DEPTH-1:0][SCORE_W-1:0] score_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [K-1:0] pos_ok;
    for (genvar p = 0; p < K; p++) begin : g_pos
      assign pos_ok[p] = tbl_i[e].wild[p] ||
                         (tbl_i[e].syms[p*SYM_W +: SYM_W] == win_i[p*SYM_W +: SYM_W]);
    end
    assign hit_o[e] = tbl_i[e].vld && (&pos_ok);
    always_comb begin
      score_o[e] = '0;
      for (int p = 0; p < K; p++)
        if (!tbl_i[e].wild[p]) score_o[e] = score_o[e] + SCORE_W'(1);
    end
  end
endmodule

// File: rtl/ksym_pick.sv
module ksym_pick
  import ksym_pkg::*;
(
  input  logic [DEPTH-1:0]              hit_i,
  input  logic [DEPTH-1:0][SCORE_W-1:0] score_i,
  output logic                          found_o,
  output logic [AW-1:0]                 idx_o
);
  logic [SCORE_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (hit_i[e] && (!found_o || score_i[e] > best)) begin
        found_o = 1'b1;
        idx_o   = AW'(e);
        best    = score_i[e];
      end
    end
  end
endmodule

// File: rtl/ksym_classifier.sv
module ksym_classifier
  import ksym_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [K*SYM_W-1:0]   in_syms,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [K*SYM_W-1:0]   wr_syms,
  input  logic [K-1:0]         wr_wild,
  input  logic [ECID_W-1:0]    wr_ecid,
  input  logic                 wr_valid,
  output logic                 out_valid,
  output logic [ECID_W-1:0]    out_ecid
);
  kent_t [DEPTH-1:0]              tbl;
  kent_t                          wr_data;
  logic [DEPTH-1:0]               hit;
  logic [DEPTH-1:0][SCORE_W-1:0]  score;
  logic                           found;
  logic [AW-1:0]                  idx;
  logic                           vld_q, vld_nxt;
  logic [ECID_W-1:0]              ecid_q, ecid_nxt;

  assign wr_data = '{vld: wr_valid, ecid: wr_ecid, wild: wr_wild, syms: wr_syms};

  ksym_table u_table (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                      .wr_data(wr_data), .tbl_o(tbl));
  ksym_match u_match (.tbl_i(tbl), .win_i(in_syms), .hit_o(hit), .score_o(score));
  ksym_pick  u_pick  (.hit_i(hit), .score_i(score), .found_o(found), .idx_o(idx));

  always_comb begin
    vld_nxt  = in_valid;
    ecid_nxt = ecid_q;
    if (in_valid) ecid_nxt = found ? tbl[idx].ecid : DEFAULT_ECID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ecid_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      if (in_valid) ecid_q <= ecid_nxt;
    end
  end

  assign out_valid = vld_q;
  assign out_ecid  = ecid_q;

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_ecid_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ecid));
  assert_default_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit == '0) |=> out_ecid == DEFAULT_ECID);
  assert_pick_is_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> hit[idx]);
  assert_found_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found == (hit != '0));
endmodule

// File: tb/ksym_classifier_test.sv
module ksym_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, wr_en = 1'b0, wr_valid = 1'b0;
  logic [15:0] in_syms = '0, wr_syms = '0;
  logic [3:0]  wr_wild = '0;
  logic [4:0]  wr_addr = '0, wr_ecid = '0;
  logic        out_valid;
  logic [4:0]  out_ecid;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural model state
  bit       m_vld [N];
  int       m_ecid[N];
  bit [3:0] m_wild[N];
  int       m_sym [N][4];
  bit       exp_valid = 0;
  int       exp_ecid  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ksym_classifier uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_syms(in_syms),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_syms(wr_syms), .wr_wild(wr_wild),
    .wr_ecid(wr_ecid), .wr_valid(wr_valid), .out_valid(out_valid), .out_ecid(out_ecid));

  function automatic int classify(logic [15:0] w);
    int best_score = -1, res = 31;
    for (int e = 0; e < N; e++) begin
      int sc = 0;
      bit ok = m_vld[e];
      for (int p = 0; p < 4; p++) begin
        if (!m_wild[e][p]) begin
          sc++;
          if (m_sym[e][p] != int'(w[4*p +: 4])) ok = 0;
        end
      end
      if (ok && sc > best_score) begin best_score = sc; res = m_ecid[e]; end
    end
    return res;
  endfunction

  task automatic check(string tag);
    compared++;
    if (out_valid !== exp_valid || int'(out_ecid) !== exp_ecid) begin
      mismatched++;
      $display("FAIL %s: valid=%0b ecid=%0d expected valid=%0b ecid=%0d",
               tag, out_valid, out_ecid, exp_valid, exp_ecid);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    #1;
    exp_valid = in_valid;
    if (in_valid) exp_ecid = classify(in_syms);
    if (wr_en) begin
      m_vld[wr_addr]  = wr_valid;
      m_ecid[wr_addr] = wr_ecid;
      m_wild[wr_addr] = wr_wild;
      for (int p = 0; p < 4; p++) m_sym[wr_addr][p] = wr_syms[4*p +: 4];
    end
    @(negedge clk);
    check(tag);
    in_valid = 0;
    wr_en = 0;
  endtask

  function automatic logic [15:0] pk(int s0, int s1, int s2, int s3);
    return {4'(s3), 4'(s2), 4'(s1), 4'(s0)};
  endfunction

  task automatic put(int a, logic [15:0] s, logic [3:0] wl, int ec, bit v);
    wr_en = 1; wr_addr = 5'(a); wr_syms = s; wr_wild = wl; wr_ecid = 5'(ec); wr_valid = v;
  endtask

  task automatic look(logic [15:0] s);
    in_valid = 1; in_syms = s;
  endtask

  localparam int A = 1, B = 2, C = 3, D = 4;

  initial begin
    for (int e = 0; e < N; e++) begin
      m_vld[e] = 0; m_ecid[e] = 0; m_wild[e] = 0;
      for (int p = 0; p < 4; p++) m_sym[e][p] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    step("R1 idle after reset");
    look(pk(D, B, A, B)); step("R1 R6 empty table gives default");

    // DB~~ idx5 ecid7, ~~AB idx2 ecid4, DBAB idx10 ecid3
    put(5, pk(D, B, 0, 0), 4'b1100, 7, 1); step("R9 write");
    put(2, pk(0, 0, A, B), 4'b0011, 4, 1); step("R9 write");
    put(10, pk(D, B, A, B), 4'b0000, 3, 1); look(pk(D, B, A, B));
    step("R9 same-edge lookup sees old table");
    look(pk(D, B, A, B)); step("R4 concrete entry beats partials");
    look(pk(D, B, C, C)); step("R2 R3 leading concrete match");
    look(pk(C, C, A, B)); step("R3 trailing concrete match");
    look(pk(C, C, C, C)); step("R6 miss gives default");
    look(pk(B, D, B, A)); step("R2 position order matters");
    step("R8 hold while idle");
    step("R8 hold while idle");
    put(20, pk(D, 0, 0, B), 4'b0110, 12, 1); step("R9 write");
    look(pk(D, B, C, B)); step("R5 tie goes to lower index");
    put(0, pk(0, B, 0, B), 4'b0101, 9, 1); step("R9 write");
    look(pk(D, B, C, B)); step("R5 new lower index wins tie");
    put(10, pk(D, B, A, B), 4'b0000, 3, 0); step("R10 remove");
    look(pk(D, B, A, B)); step("R10 removed entry not chosen");
    put(31, pk(0, 0, 0, 0), 4'b1111, 17, 1); step("R3 all-wild entry");
    look(pk(C, C, C, C)); step("R3 all-wild catches rest");
    look(pk(D, B, A, B)); step("R4 all-wild loses to specific");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0)
        put($urandom_range(0, N-1), 16'($urandom) & 16'h3333, 4'($urandom),
            $urandom_range(0, 31), $urandom_range(0, 4) != 0);
      if ($urandom_range(0, 3) != 0) look(16'($urandom) & 16'h3333);
      step("R4 R5 R7 R8 random traffic");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL R7 watchdog: run hung, actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule